// File: doc/BRIEF.md
# Interrupt Latch and Pad Router

This block sits between the logic that detects interrupt conditions and the two interrupt pins of a sensor-style device. It accepts two interrupt-condition inputs, a data-ready strobe and a boot-in-progress flag, and drives two registered interrupt pads.

Each of the two interrupt paths can run in one of two modes. In pass-through mode, its request is simply the live condition. In hold mode, a condition pulse is captured and kept until software reads that path's status register. The read clears the held request as a side effect.

Each pad has its own 2-bit route code. The code picks one of four signals for the pad:
- the pad's own path request;
- the OR of both path requests;
- the data-ready strobe;
- the boot flag.

A small synchronous register port gives software access to the mode and route settings and to the two status registers.

Top module: `irq_pad_router`

## Requirements
- R1: After reset the control register reads 0x00 (both paths in pass-through mode, both route codes 00), both pads are low, and both status registers read 0 while the conditions are low.
- R2: In pass-through mode, bit 0 of a path's status register shows the live condition in the same cycle. Reading that register has no effect on later reads or on the pad.
- R3: In hold mode, a condition that is high for one cycle keeps the path request high in every later cycle until the path's status register is read.
- R4: In hold mode, reading the path's status register (address 1 for path 0, address 2 for path 1) while the condition is low drops the request from the next cycle on.
- R5: In hold mode, if the condition is high in the same cycle as the clearing read, the request stays set in the following cycle.
- R6: Writing a path's hold bit from 1 to 0 releases any held request. From the next cycle the request equals the live condition.
- R7: Route code 00 puts the pad's own path request on the pad: path 0 on pad 0, path 1 on pad 1.
- R8: Route code 01 puts the OR of both path requests on the pad.
- R9: Route code 10 puts the data-ready strobe on the pad, and route code 11 puts the boot flag on the pad.
- R10: Pads are registered. A pad shows the routed value of the previous clock cycle.
- R11: The control register is at address 0, with this layout:
  - bits [1:0]: pad 0 route code
  - bit 2: path 0 hold enable
  - bits [4:3]: pad 1 route code
  - bit 5: path 1 hold enable
  - bits [7:6]: read as 0

  Status bit 0 is the path request and the upper status bits read 0. Address 3 reads 0. Writes to addresses 1 to 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 2 | Interrupt conditions, bit k for path k |
| drdy_i | input | 1 | Data-ready strobe |
| boot_i | input | 1 | Boot-in-progress flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (triggers clear-on-read) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| pad_o | output | 2 | Registered interrupt pads |

## Verification
The bound checker checks four behaviours on every cycle:
- the routing of each pad against the previous cycle's request, data-ready and boot values;
- that a held request survives a clearing read when a new event coincides with it;
- that a clearing read with no event drops the request;
- that a disabled hold bit keeps nothing held.

Three properties can only be shown by the bench's scenarios, because they depend on the register map and on the exact order of writes, reads and pulses:
- the register layout and the reads of unused addresses;
- that a read in pass-through mode has no side effect;
- the release of a held request at the moment hold mode is switched off.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [1:0] {
    ROUTE_OWN  = 2'b00,
    ROUTE_ANY  = 2'b01,
    ROUTE_DRDY = 2'b10,
    ROUTE_BOOT = 2'b11
  } route_e;

  // Per-path control field: hold bit above the 2-bit route code
  typedef struct packed {
    logic   hold_en;
    route_e route;
  } path_ctrl_t;

  localparam int PATH_CTRL_W = $bits(path_ctrl_t);

  function automatic logic route_pick(route_e code, logic own, logic any,
                                      logic drdy, logic boot);
    logic res;
    unique case (code)
      ROUTE_OWN:  res = own;
      ROUTE_ANY:  res = any;
      ROUTE_DRDY: res = drdy;
      default:    res = boot;
    endcase
    return res;
  endfunction

  function automatic logic hold_next(logic hold_en, logic cond, logic held,
                                     logic clr);
    return hold_en & (cond | (held & ~clr));
  endfunction

endpackage

// File: rtl/irq_hold_cell.sv
module irq_hold_cell
  import irq_router_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_en,
  input  logic cond,
  input  logic clr_rd,
  output logic held,
  output logic req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= hold_next(hold_en, cond, held, clr_rd);
  end

  assign req = hold_en ? (held | cond) : cond;

endmodule

// File: rtl/irq_pad_sel.sv
module irq_pad_sel
  import irq_router_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_e route,
  input  logic   own,
  input  logic   any,
  input  logic   drdy,
  input  logic   boot,
  output logic   pad
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pad <= 1'b0;
    else        pad <= route_pick(route, own, any, drdy, boot);
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int NPATH    = 2,
  parameter int CTRL_W   = 6,
  parameter int SRC_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPATH-1:0]  req,
  output logic [CTRL_W-1:0] ctrl,
  output logic [NPATH-1:0]  clr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic [NPATH-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ctrl <= '0;
    else if (we && addr == CTRL_ADDR) ctrl <= wdata[CTRL_W-1:0];
  end

  for (genvar k = 0; k < NPATH; k++) begin : g_dec
    assign hit[k] = (addr == ADDR_W'(SRC_BASE + k));
    assign clr[k] = re & hit[k];
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = DATA_W'(ctrl);
    for (int k = 0; k < NPATH; k++)
      if (hit[k]) rdata = DATA_W'(req[k]);
  end

endmodule

// File: rtl/irq_pad_router.sv
module irq_pad_router
  import irq_router_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        irq_src_i,
  input  logic              drdy_i,
  input  logic              boot_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [1:0]        pad_o
);

  localparam int NPATH  = 2;
  localparam int CTRL_W = NPATH * PATH_CTRL_W;

  // Internal events, named for the bound checker
  logic [CTRL_W-1:0]  ctrl_w;
  logic [NPATH-1:0]   req_w;
  logic [NPATH-1:0]   held_w;
  logic [NPATH-1:0]   clr_w;
  logic [NPATH-1:0]   len_w;
  logic [2*NPATH-1:0] sel_w;
  logic               any_w;

  irq_ctrl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NPATH(NPATH),
    .CTRL_W(CTRL_W), .SRC_BASE(1)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .re(reg_re_i),
    .addr(reg_addr_i), .wdata(reg_wdata_i), .req(req_w),
    .ctrl(ctrl_w), .clr(clr_w), .rdata(reg_rdata_o)
  );

  assign any_w = |req_w;

  for (genvar k = 0; k < NPATH; k++) begin : g_path
    path_ctrl_t pc;
    assign pc             = ctrl_w[k*PATH_CTRL_W +: PATH_CTRL_W];
    assign len_w[k]       = pc.hold_en;
    assign sel_w[2*k +: 2] = pc.route;

    irq_hold_cell hold_i (
      .clk(clk), .rst_n(rst_n), .hold_en(pc.hold_en), .cond(irq_src_i[k]),
      .clr_rd(clr_w[k]), .held(held_w[k]), .req(req_w[k])
    );

    irq_pad_sel pad_i (
      .clk(clk), .rst_n(rst_n), .route(pc.route), .own(req_w[k]),
      .any(any_w), .drdy(drdy_i), .boot(boot_i), .pad(pad_o[k])
    );
  end

endmodule

// File: rtl/irq_pad_router_chk.sv
module irq_pad_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] irq_src_i,
  input logic       drdy_i,
  input logic       boot_i,
  input logic [1:0] pad_o,
  input logic [1:0] req_w,
  input logic [1:0] held_w,
  input logic [1:0] clr_w,
  input logic [1:0] len_w,
  input logic [3:0] sel_w
);

  // R7
  own_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_w[1:0]) == 2'b00) |-> pad_o[0] == $past(req_w[0]));

  // R8
  any_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_w[3:2]) == 2'b01) |-> pad_o[1] == $past(req_w[0] | req_w[1]));

  // R9
  drdy_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_w[1:0]) == 2'b10) |-> pad_o[0] == $past(drdy_i));

  // R9
  boot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sel_w[3:2]) == 2'b11) |-> pad_o[1] == $past(boot_i));

  for (genvar k = 0; k < 2; k++) begin : g_p
    // R5
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_w[k] && len_w[k] && irq_src_i[k]) |-> held_w[k]);

    // R4
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_w[k] && len_w[k] && !irq_src_i[k]) |-> !held_w[k]);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!len_w[k]) |-> !held_w[k]);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(len_w[k] && irq_src_i[k]) && len_w[k]) |-> req_w[k]);
  end

endmodule

bind irq_pad_router irq_pad_router_chk chk_i (.*);

// File: tb/irq_pad_router_tb_top.sv
module irq_pad_router_tb_top;
  timeunit 1ns; timeprecision 1ps;

  typedef struct {
    int         cyc;
    logic [1:0] pad;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] irq_src_i = '0;
  logic       drdy_i = 1'b0, boot_i = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [1:0] pad_o;

  int   checks = 0, errors = 0, cyc = 0;
  bit   done = 0;
  exp_t sb[$];

  logic [5:0] m_ctrl = '0;
  logic [1:0] m_held = '0;

  always #4 clk = ~clk;

  irq_pad_router dut_i (.*);

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic pick(logic [1:0] c, logic own, logic [1:0] r,
                                logic d, logic b);
    if (c[1]) return c[0] ? b : d;
    return c[0] ? (r[0] | r[1]) : own;
  endfunction

  // Monitor: compare pads with what the driver predicted
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pad_o !== e.pad) begin
        errors++;
        $display("FAIL %s pad actual %b expected %b (cycle %0d)",
                 e.tag, pad_o, e.pad, cyc);
      end
    end
  end

  task automatic chk_rd(string tag, logic [7:0] exp);
    checks++;
    if (reg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s rdata actual %h expected %h", tag, reg_rdata_o, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, predict results, push to scoreboard
  task automatic drive(logic [1:0] src, logic d, logic b, logic we, logic re,
                       logic [1:0] a, logic [7:0] wd, string tag);
    logic [1:0] r;
    logic [1:0] p;
    @(negedge clk);
    irq_src_i = src; drdy_i = d; boot_i = b;
    reg_we_i = we; reg_re_i = re; reg_addr_i = a; reg_wdata_i = wd;
    #1;
    for (int k = 0; k < 2; k++)
      r[k] = m_ctrl[3*k+2] ? (m_held[k] | src[k]) : src[k];
    if (re) begin
      case (a)
        2'd0: chk_rd(tag, {2'b00, m_ctrl});
        2'd1: chk_rd(tag, {7'd0, r[0]});
        2'd2: chk_rd(tag, {7'd0, r[1]});
        default: chk_rd(tag, 8'h00);
      endcase
    end
    p[0] = pick(m_ctrl[1:0], r[0], r, d, b);
    p[1] = pick(m_ctrl[4:3], r[1], r, d, b);
    sb.push_back('{cyc + 1, p, tag});
    for (int k = 0; k < 2; k++) begin
      logic c;
      c = re && (a == 2'(k + 1));
      m_held[k] = m_ctrl[3*k+2] ? (src[k] | (m_held[k] & ~c)) : 1'b0;
    end
    if (we && a == 2'd0) m_ctrl = wd[5:0];
  endtask

  task automatic idle(logic [1:0] src, string tag);
    drive(src, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, tag);
  endtask

  task automatic rd(logic [1:0] src, logic [1:0] a, string tag);
    drive(src, 1'b0, 1'b0, 1'b0, 1'b1, a, 8'h00, tag);
  endtask

  task automatic wr(logic [7:0] v, string tag);
    drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, v, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    reg_re_i = 1'b1;
    #20;
    checks++;
    if (pad_o !== 2'b00) begin
      errors++;
      $display("FAIL R1 pad actual %b expected 00", pad_o);
    end
    chk_rd("R1", 8'h00);
    reg_re_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'b00, 2'd1, "R1");
    rd(2'b00, 2'd2, "R1");

    // R7 / R10: own source on each pad
    idle(2'b01, "R7");
    idle(2'b10, "R7");
    idle(2'b11, "R10");
    idle(2'b00, "R10");

    // R2: pass-through status follows live, read has no side effect
    rd(2'b01, 2'd1, "R2");
    rd(2'b00, 2'd1, "R2");
    rd(2'b10, 2'd2, "R2");
    rd(2'b00, 2'd2, "R2");

    // R3: hold mode on path 0
    wr(8'h04, "R11");
    rd(2'b00, 2'd0, "R11");
    idle(2'b01, "R3");
    idle(2'b00, "R3");
    idle(2'b00, "R3");
    rd(2'b00, 2'd1, "R4");
    idle(2'b00, "R4");
    rd(2'b00, 2'd1, "R4");

    // R5: event coincides with clearing read
    rd(2'b01, 2'd1, "R5");
    rd(2'b00, 2'd1, "R5");
    rd(2'b00, 2'd1, "R5");

    // R6: release on hold disable
    wr(8'h24, "R6");
    idle(2'b11, "R6");
    idle(2'b00, "R6");
    wr(8'h20, "R6");
    rd(2'b00, 2'd1, "R6");
    rd(2'b00, 2'd2, "R6");
    wr(8'h00, "R6");
    rd(2'b00, 2'd2, "R6");

    // R8: OR route on both pads
    wr(8'h09, "R8");
    idle(2'b01, "R8");
    idle(2'b10, "R8");
    idle(2'b00, "R8");
    idle(2'b11, "R8");

    // R9: data-ready on pad 0, boot on pad 1
    wr(8'h1A, "R9");
    drive(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
    drive(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
    drive(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, "R9");
    drive(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00, "R9");

    // R11: map, unused address, ignored writes
    rd(2'b00, 2'd0, "R11");
    drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'hFF, "R11");
    drive(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 8'hFF, "R11");
    rd(2'b00, 2'd0, "R11");
    rd(2'b00, 2'd3, "R11");
    wr(8'hFF, "R11");
    rd(2'b00, 2'd0, "R11");
    wr(8'h00, "R11");
    idle(2'b00, "R11");
    idle(2'b00, "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule